// File: doc/BRIEF.md
# Byte-Stuffing Frame Codec

This block carries packets over a plain byte link, such as a serial line, using flag-delimited framing with byte stuffing. The transmit half takes a packet one byte at a time, with markers on the first and last byte. It puts a flag byte (0x7E) on the line before and after the packet. Any payload byte that would be mistaken for a flag or an escape is replaced by an escape byte (0x7D) and a modified copy of itself. Because one payload byte can become two line bytes, the transmit half pushes back on its source through its ready signal.

The receive half works in the opposite direction. It takes line bytes and removes flags and escapes. It restores each escaped byte and hands the packets on with first-byte and last-byte markers. It keeps one payload byte back so that it can tag that byte as the last one when a flag arrives. A flag that lands directly after an escape byte is treated as a broken frame: the kept-back byte is thrown away and a one-cycle abort pulse is raised.

All four byte streams use valid/ready handshakes. A byte moves on a rising clock edge when valid and ready are both high.

Top module: `frm_codec`

## Requirements
- R1: For a packet whose first byte carries `tx_sop_i`, the transmitter sends 0x7E, then the stuffed payload, then 0x7E after the byte that carries `tx_eop_i`.
- R2: A payload byte 0x7E goes on the line as 0x7D 0x5E, and a payload byte 0x7D goes on the line as 0x7D 0x5D (the second byte is the original XOR 0x20). Every other byte value goes on the line unchanged.
- R3: `tx_ready_o` stays low for every cycle in which the second byte of an escape pair is waiting on the line.
- R4: Outside a frame, the transmitter accepts a byte offered without `tx_sop_i` (`tx_ready_o` high), throws it away, and puts nothing on the line.
- R5: While `line_valid_o` is high and `line_ready_i` is low, the line byte and its valid stay unchanged.
- R6: The receiver removes all flag and escape bytes. It restores the byte that follows an escape by XOR with 0x20, so that a looped-back packet comes out byte for byte equal to the packet that went in.
- R7: The first payload byte after a flag comes out with `out_sop_o` high. The byte held when a closing flag arrives comes out with `out_eop_o` high. Every other byte has both markers low.
- R8: Two or more flags with no payload between them produce no output byte.
- R9: A flag accepted directly after an escape byte raises `out_abort_o` for one cycle. The held byte is dropped and never comes out, and the next payload byte starts a new frame.
- R10: While `out_valid_o` is high and `out_ready_i` is low, the output byte and its markers stay unchanged.
- R11: After reset, `line_valid_o`, `out_valid_o` and `out_abort_o` are low and `rx_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_data_i | input | 8 | Payload byte to send |
| tx_sop_i | input | 1 | Marks the first byte of a packet |
| tx_eop_i | input | 1 | Marks the last byte of a packet |
| tx_valid_i | input | 1 | Payload byte is offered |
| tx_ready_o | output | 1 | Transmitter takes the offered byte |
| line_data_o | output | 8 | Framed byte to the line |
| line_valid_o | output | 1 | Line byte is offered |
| line_ready_i | input | 1 | Line takes the byte |
| rx_data_i | input | 8 | Framed byte from the line |
| rx_valid_i | input | 1 | Received line byte is offered |
| rx_ready_o | output | 1 | Receiver takes the line byte |
| out_data_o | output | 8 | Recovered payload byte |
| out_sop_o | output | 1 | First byte of a received frame |
| out_eop_o | output | 1 | Last byte of a received frame |
| out_valid_o | output | 1 | Recovered byte is offered |
| out_ready_i | input | 1 | Sink takes the recovered byte |
| out_abort_o | output | 1 | One-cycle pulse: frame broken by a flag after an escape |

## Verification
The line hold property (R5) assumes that the payload source follows the handshake rule. Once `tx_valid_i` is high, the source keeps the byte and its markers steady until `tx_ready_o` takes them, because the transmitter builds its line byte straight from that input. The bench source only changes its inputs after a completed handshake. The bench also drops `line_valid_o` and `line_ready_i` together when it stalls the loopback, so the receiver never sees a byte that the transmitter does not count as sent. The decoder-side properties assume nothing about the line contents, and the bench injects line bytes directly to reach the repeated-flag and abort cases.

// File: rtl/frm_pkg.sv
package frm_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FLAG_B = 8'h7E;
  localparam logic [BYTE_W-1:0] ESC_B  = 8'h7D;
  localparam logic [BYTE_W-1:0] FLIP_M = 8'h20;

  typedef enum logic [1:0] {
    ENC_IDLE,
    ENC_BODY,
    ENC_ESC,
    ENC_CLOSE
  } enc_state_e;

  function automatic logic is_reserved(input logic [BYTE_W-1:0] b);
    return (b == FLAG_B) || (b == ESC_B);
  endfunction
endpackage

// File: rtl/frm_encoder.sv
module frm_encoder
  import frm_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] tx_data_i,
  input  logic         tx_sop_i,
  input  logic         tx_eop_i,
  input  logic         tx_valid_i,
  output logic         tx_ready_o,
  output logic [W-1:0] line_data_o,
  output logic         line_valid_o,
  input  logic         line_ready_i
);
  enc_state_e   state_q, state_d;
  logic [W-1:0] pend_q;
  logic         pend_eop_q;
  logic         resv;
  logic         take_resv;

  assign resv      = is_reserved(tx_data_i);
  assign take_resv = (state_q == ENC_BODY) && tx_valid_i && line_ready_i && resv;

  always_comb begin
    state_d      = state_q;
    line_data_o  = FLAG_B;
    line_valid_o = 1'b0;
    tx_ready_o   = 1'b0;
    unique case (state_q)
      ENC_IDLE: begin
        // bytes without a start marker are swallowed
        tx_ready_o   = !tx_sop_i;
        line_valid_o = tx_valid_i && tx_sop_i;
        if (line_valid_o && line_ready_i) state_d = ENC_BODY;
      end
      ENC_BODY: begin
        line_valid_o = tx_valid_i;
        line_data_o  = resv ? ESC_B : tx_data_i;
        tx_ready_o   = line_ready_i;
        if (tx_valid_i && line_ready_i) begin
          if (resv)          state_d = ENC_ESC;
          else if (tx_eop_i) state_d = ENC_CLOSE;
        end
      end
      ENC_ESC: begin
        line_valid_o = 1'b1;
        line_data_o  = pend_q;
        if (line_ready_i) state_d = pend_eop_q ? ENC_CLOSE : ENC_BODY;
      end
      default: begin
        line_valid_o = 1'b1;
        if (line_ready_i) state_d = ENC_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ENC_IDLE;
      pend_q     <= '0;
      pend_eop_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take_resv) begin
        pend_q     <= tx_data_i ^ FLIP_M;
        pend_eop_q <= tx_eop_i;
      end
    end
  end

  p_esc_stall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o && line_ready_i && line_data_o == ESC_B |=> !tx_ready_o && line_valid_o);

  p_esc_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o && line_ready_i && line_data_o == ESC_B |=>
      line_data_o != FLAG_B && line_data_o != ESC_B);

  p_line_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o && !line_ready_i |=> line_valid_o && $stable(line_data_o));
endmodule

// File: rtl/frm_decoder.sv
module frm_decoder
  import frm_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] rx_data_i,
  input  logic         rx_valid_i,
  output logic         rx_ready_o,
  output logic [W-1:0] out_data_o,
  output logic         out_sop_o,
  output logic         out_eop_o,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic         out_abort_o
);
  logic [W-1:0] hold_q;
  logic         hold_sop_q, hold_vld_q;
  logic         esc_q, first_q, abort_q;
  logic [W-1:0] out_q;
  logic         out_sop_q, out_eop_q, out_vld_q;
  logic         accept, is_flag, is_esc;
  logic [W-1:0] plain;

  assign rx_ready_o = !out_vld_q || out_ready_i;
  assign accept     = rx_valid_i && rx_ready_o;
  assign is_flag    = rx_data_i == FLAG_B;
  assign is_esc     = rx_data_i == ESC_B;
  assign plain      = esc_q ? (rx_data_i ^ FLIP_M) : rx_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= '0;
      hold_sop_q <= 1'b0;
      hold_vld_q <= 1'b0;
      esc_q      <= 1'b0;
      first_q    <= 1'b1;
      abort_q    <= 1'b0;
      out_q      <= '0;
      out_sop_q  <= 1'b0;
      out_eop_q  <= 1'b0;
      out_vld_q  <= 1'b0;
    end else begin
      abort_q <= 1'b0;
      if (out_vld_q && out_ready_i) out_vld_q <= 1'b0;
      if (accept) begin
        if (is_flag) begin
          first_q    <= 1'b1;
          esc_q      <= 1'b0;
          hold_vld_q <= 1'b0;
          if (esc_q) begin
            abort_q <= 1'b1;  // held byte discarded
          end else if (hold_vld_q) begin
            out_q     <= hold_q;
            out_sop_q <= hold_sop_q;
            out_eop_q <= 1'b1;
            out_vld_q <= 1'b1;
          end
        end else if (is_esc && !esc_q) begin
          esc_q <= 1'b1;
        end else begin
          esc_q <= 1'b0;
          if (hold_vld_q) begin
            out_q     <= hold_q;
            out_sop_q <= hold_sop_q;
            out_eop_q <= 1'b0;
            out_vld_q <= 1'b1;
          end
          hold_q     <= plain;
          hold_sop_q <= first_q;
          hold_vld_q <= 1'b1;
          first_q    <= 1'b0;
        end
      end
    end
  end

  assign out_data_o  = out_q;
  assign out_sop_o   = out_sop_q;
  assign out_eop_o   = out_eop_q;
  assign out_valid_o = out_vld_q;
  assign out_abort_o = abort_q;

  p_out_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=>
      out_valid_o && $stable(out_data_o) && $stable(out_eop_o) && $stable(out_sop_o));

  p_abort_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && is_flag && esc_q |=> out_abort_o && !hold_vld_q);

  p_close_eop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && is_flag && !esc_q && hold_vld_q |=> out_valid_o && out_eop_o);

  p_abort_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_abort_o |=> !out_abort_o);
endmodule

// File: rtl/frm_codec.sv
module frm_codec
  import frm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] tx_data_i,
  input  logic       tx_sop_i,
  input  logic       tx_eop_i,
  input  logic       tx_valid_i,
  output logic       tx_ready_o,
  output logic [7:0] line_data_o,
  output logic       line_valid_o,
  input  logic       line_ready_i,
  input  logic [7:0] rx_data_i,
  input  logic       rx_valid_i,
  output logic       rx_ready_o,
  output logic [7:0] out_data_o,
  output logic       out_sop_o,
  output logic       out_eop_o,
  output logic       out_valid_o,
  input  logic       out_ready_i,
  output logic       out_abort_o
);
  frm_encoder #(.W(BYTE_W)) u_enc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tx_data_i   (tx_data_i),
    .tx_sop_i    (tx_sop_i),
    .tx_eop_i    (tx_eop_i),
    .tx_valid_i  (tx_valid_i),
    .tx_ready_o  (tx_ready_o),
    .line_data_o (line_data_o),
    .line_valid_o(line_valid_o),
    .line_ready_i(line_ready_i)
  );

  frm_decoder #(.W(BYTE_W)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_data_i  (rx_data_i),
    .rx_valid_i (rx_valid_i),
    .rx_ready_o (rx_ready_o),
    .out_data_o (out_data_o),
    .out_sop_o  (out_sop_o),
    .out_eop_o  (out_eop_o),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .out_abort_o(out_abort_o)
  );
endmodule

// File: tb/frm_codec_test.sv
`timescale 1ns/1ps
module frm_codec_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0] tx_data = '0;
  logic tx_sop = 1'b0, tx_eop = 1'b0, tx_valid = 1'b0;
  logic tx_ready;
  logic [7:0] line_data;
  logic line_valid, line_ready;
  logic [7:0] rx_data, rx_data_d = '0;
  logic rx_valid, rx_valid_d = 1'b0, rx_ready;
  logic [7:0] out_data;
  logic out_sop, out_eop, out_valid, out_abort;
  logic out_ready = 1'b1;
  logic direct = 1'b0, gate = 1'b1, stall_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  assign rx_data    = direct ? rx_data_d : line_data;
  assign rx_valid   = direct ? rx_valid_d : (line_valid && gate);
  assign line_ready = !direct && gate && rx_ready;

  frm_codec uut (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_data_i(tx_data), .tx_sop_i(tx_sop), .tx_eop_i(tx_eop),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .line_data_o(line_data), .line_valid_o(line_valid), .line_ready_i(line_ready),
    .rx_data_i(rx_data), .rx_valid_i(rx_valid), .rx_ready_o(rx_ready),
    .out_data_o(out_data), .out_sop_o(out_sop), .out_eop_o(out_eop),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_abort_o(out_abort)
  );

  int checks = 0, errors = 0, aborts = 0, cycles = 0;
  logic [7:0]  exp_line[$];
  logic [9:0]  exp_out[$];  // {sop, eop, data}

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    gate      = !stall_en || lfsr[0] || lfsr[3];
    out_ready = !stall_en || lfsr[5] || lfsr[7];
  end

  // monitors, sampled on the falling edge
  logic ln_stall = 1'b0, out_stall = 1'b0, esc_wait = 1'b0;
  logic [7:0] ln_prev = '0;
  logic [9:0] out_prev = '0;
  always @(negedge clk) if (rst_n) begin
    if (ln_stall)
      chk(line_valid && line_data == ln_prev, "R5 line hold", line_data, ln_prev);
    if (out_stall)
      chk(out_valid && {out_sop, out_eop, out_data} == out_prev, "R10 out hold",
          {out_sop, out_eop, out_data}, out_prev);
    if (esc_wait)
      chk(!tx_ready, "R3 ready low in escape pair", tx_ready, 0);
    if (line_valid && line_ready) begin
      if (exp_line.size() == 0) chk(1'b0, "R1 extra line byte", line_data, 0);
      else begin
        logic [7:0] e;
        e = exp_line.pop_front();
        chk(line_data == e, "R1/R2 line byte", line_data, e);
      end
      esc_wait = (line_data == 8'h7D);
    end
    if (out_valid && out_ready) begin
      if (exp_out.size() == 0) chk(1'b0, "R6 extra out byte", out_data, 0);
      else begin
        logic [9:0] e;
        e = exp_out.pop_front();
        chk({out_sop, out_eop, out_data} == e, "R6/R7 out byte",
            {out_sop, out_eop, out_data}, e);
      end
    end
    if (out_abort) aborts++;
    ln_stall  = line_valid && !line_ready;
    ln_prev   = line_data;
    out_stall = out_valid && !out_ready;
    out_prev  = {out_sop, out_eop, out_data};
  end

  function automatic logic [7:0] pat(input int len, input int i);
    logic [7:0] t[8] = '{8'h7E, 8'h7D, 8'h5E, 8'h5D, 8'h00, 8'hFF, 8'h20, 8'h41};
    return t[(i * 3 + len) % 8];
  endfunction

  task automatic push_enc(input logic [7:0] b);
    if (b == 8'h7E || b == 8'h7D) begin
      exp_line.push_back(8'h7D);
      exp_line.push_back(b ^ 8'h20);
    end else exp_line.push_back(b);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic s, input logic e);
    logic r;
    tx_data = b; tx_sop = s; tx_eop = e; tx_valid = 1'b1;
    do begin
      @(negedge clk); r = tx_ready;
      @(posedge clk); #1;
    end while (!r);
    tx_valid = 1'b0; tx_sop = 1'b0; tx_eop = 1'b0;
  endtask

  task automatic drive_line(input logic [7:0] b);
    logic r;
    rx_data_d = b; rx_valid_d = 1'b1;
    do begin
      @(negedge clk); r = rx_ready;
      @(posedge clk); #1;
    end while (!r);
    rx_valid_d = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_line.size() != 0 || exp_out.size() != 0) && n < 5000) begin
      @(posedge clk); n++;
    end
    repeat (4) @(posedge clk);
    #1;
    chk(exp_line.size() == 0, "R1 line queue empty", exp_line.size(), 0);
    chk(exp_out.size() == 0, "R6 out queue empty", exp_out.size(), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!line_valid, "R11 line_valid reset", line_valid, 0);
    chk(!out_valid, "R11 out_valid reset", out_valid, 0);
    chk(!out_abort, "R11 abort reset", out_abort, 0);
    chk(rx_ready, "R11 rx_ready reset", rx_ready, 1);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;

    // R4: bytes without start marker outside a frame are dropped
    for (int i = 0; i < 3; i++) begin
      tx_data = 8'h7E - i[7:0]; tx_valid = 1'b1;
      @(negedge clk);
      chk(tx_ready, "R4 stray byte accepted", tx_ready, 1);
      chk(!line_valid, "R4 stray byte not sent", line_valid, 0);
      @(posedge clk); #1;
    end
    tx_valid = 1'b0;
    drain();

    // R1 R2 R6 R7: all byte values in one frame, first without stalls then with
    for (int pass = 0; pass < 2; pass++) begin
      stall_en = (pass == 1);
      exp_line.push_back(8'h7E);
      for (int i = 0; i < 256; i++) begin
        push_enc(i[7:0]);
        exp_out.push_back({i == 0, i == 255, i[7:0]});
      end
      exp_line.push_back(8'h7E);
      for (int i = 0; i < 256; i++) send_byte(i[7:0], i == 0, i == 255);
      drain();
    end

    // short frames, heavy on reserved values, under stalls (R3 R5 R10)
    stall_en = 1'b1;
    for (int len = 1; len <= 8; len++) begin
      exp_line.push_back(8'h7E);
      for (int i = 0; i < len; i++) begin
        push_enc(pat(len, i));
        exp_out.push_back({i == 0, i == len - 1, pat(len, i)});
      end
      exp_line.push_back(8'h7E);
      for (int i = 0; i < len; i++) send_byte(pat(len, i), i == 0, i == len - 1);
    end
    drain();
    stall_en = 1'b0;
    repeat (2) @(posedge clk);
    #1;

    // R8: repeated flags produce no empty frame
    direct = 1'b1;
    exp_out.push_back({1'b1, 1'b1, 8'h41});
    drive_line(8'h7E); drive_line(8'h7E); drive_line(8'h7E);
    drive_line(8'h41);
    drive_line(8'h7E); drive_line(8'h7E);
    drain();

    // R9: flag after escape aborts; held 0x42 dropped
    aborts = 0;
    exp_out.push_back({1'b1, 1'b0, 8'h41});
    exp_out.push_back({1'b1, 1'b1, 8'h43});
    drive_line(8'h7E); drive_line(8'h41); drive_line(8'h42);
    drive_line(8'h7D); drive_line(8'h7E);
    drive_line(8'h43); drive_line(8'h7E);
    drain();
    chk(aborts == 1, "R9 abort pulses", aborts, 1);

    // R6: escaped plain byte restored (7D 61 -> 41)
    exp_out.push_back({1'b1, 1'b1, 8'h41});
    drive_line(8'h7D); drive_line(8'h61); drive_line(8'h7E);
    drain();
    direct = 1'b0;

    finish_run();
  end
endmodule